// File: doc/BRIEF.md
# Security State Holder with Backdoor Unlock

This block keeps the security state of a non-volatile memory subsystem and offers a controlled way to lift it. During the boot sequence a security byte is loaded from non-volatile storage. Bits 1:0 of that byte hold a two-bit state code in which only one pattern means "open" and the other three mean "locked". Bit 7 allows the backdoor, and bits 6:2 are free flags for the user. While the block is locked, the block refuses read requests from the debug port and from the external bus.

Software unlocks the device in a fixed order. It sets the key-access bit, writes four 16-bit key words to a small window of memory addresses, and then clears the key-access bit. While key access is set, memory writes are taken in as key words and are not passed on as program or erase command starts. Clearing key access compares the collected words with a 64-bit key held in a preloaded register. On a match the state code is forced to the open pattern. On any mismatch the state stays locked and a one-cycle violation pulse goes out. The collected words are discarded after every comparison.

Top module: `sec_backdoor_top`

## Requirements
- R1: After reset `sec_byte` is 8'h00, `secured` is 1, `key_acc` is 0, `viol` is 0 and no read grant is given.
- R2: A cycle with `boot_load`=1 places `boot_byte` in `sec_byte` at the next clock edge. `secured` is 0 only when `sec_byte[1:0]` equals 2'b10, and 1 for the codes 2'b00, 2'b01 and 2'b11.
- R3: A write with `cfg_wr`=1 and `cfg_key_acc`=1 sets `key_acc` at the next edge only when `sec_byte[7]` (backdoor enable) is 1. Otherwise `key_acc` stays 0.
- R4: `cmd_wr` follows `mem_wr` in the same cycle while `key_acc` is 0, and stays 0 while `key_acc` is 1.
- R5: A key-access write to address `KEY_BASE`+2*i (i = 0..3, even address) stores key word i. Word 0 is compared with `key_store[63:48]` and word 3 with `key_store[15:0]`.
- R6: `cfg_wr`=1 with `cfg_key_acc`=0 while `key_acc`=1 clears `key_acc` and starts the comparison. On a match, `sec_byte[1:0]` becomes 2'b10 at that edge, bits 7:2 keep their value, and `viol` stays 0.
- R7: On a mismatch `sec_byte` is unchanged and `viol` is 1 for exactly the one cycle after the clearing edge.
- R8: A comparison in which any of the four words was not written, or in which a key-access write hit an odd address or an address outside the key window, is a mismatch.
- R9: The collected words are discarded after every comparison, so a later attempt must write all four words again.
- R10: A key word written in the same cycle as the clearing of key access takes part in that comparison.
- R11: `dbg_rd_gnt` equals `dbg_rd_req` and `ext_rd_gnt` equals `ext_rd_req` while `secured` is 0. Both grants are 0 while `secured` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| boot_load | input | 1 | Loads the security byte during the boot sequence |
| boot_byte | input | 8 | Security byte read from non-volatile storage |
| key_store | input | 64 | Preloaded backdoor key |
| cfg_wr | input | 1 | Write strobe for the key-access configuration bit |
| cfg_key_acc | input | 1 | Value written to the key-access bit |
| mem_wr | input | 1 | Word write to the memory address space |
| mem_addr | input | 16 | Byte address of the memory write |
| mem_wdata | input | 16 | Data of the memory write |
| dbg_rd_req | input | 1 | Read request from the debug port |
| ext_rd_req | input | 1 | Read request from the external bus |
| sec_byte | output | 8 | Current security byte |
| secured | output | 1 | Device is locked |
| key_acc | output | 1 | Key-access mode is active |
| cmd_wr | output | 1 | Memory write passed on as a command start |
| viol | output | 1 | One-cycle security violation pulse |
| dbg_rd_gnt | output | 1 | Debug read granted |
| ext_rd_gnt | output | 1 | External-bus read granted |

## Verification
The last key word write and the clearing of key access can arrive in the same cycle. The comparison must then see the word that is being captured in that cycle, not the contents of the word registers from before it. The bench provokes this by asserting `mem_wr` for word 3 together with the clearing configuration write. It judges the result by the state code and the absence of `viol` after that single edge. A second case has a wrong word in the same position, and the bench expects a violation pulse there, which shows that the word written in that cycle is really compared.

// File: rtl/sec_bd_pkg.sv
package sec_bd_pkg;
  localparam int ADDR_W = 16;
  localparam logic [1:0] SEC_OPEN_CODE = 2'b10;

  // only one of the four two-bit codes unlocks the device
  function automatic logic code_is_open(input logic [1:0] code);
    return code == SEC_OPEN_CODE;
  endfunction

  // even address inside the key window of nwords 16-bit words
  function automatic logic addr_in_window(input logic [ADDR_W-1:0] a,
                                          input logic [ADDR_W-1:0] base,
                                          input int unsigned nwords);
    int unsigned offs;
    offs = 32'(a) - 32'(base);
    return (a >= base) && (offs < 2 * nwords) && (a[0] == 1'b0);
  endfunction

  function automatic int slot_of(input logic [ADDR_W-1:0] a,
                                 input logic [ADDR_W-1:0] base);
    return int'((32'(a) - 32'(base)) >> 1);
  endfunction
endpackage

// File: rtl/sec_key_capture.sv
module sec_key_capture import sec_bd_pkg::*; #(
  parameter int WORD_W = 16,
  parameter int KEY_WORDS = 4,
  parameter logic [ADDR_W-1:0] KEY_BASE = 16'hFF00
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          key_wr_ev,
  input  logic                          compare_ev,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [WORD_W-1:0]             wr_data,
  input  logic [WORD_W*KEY_WORDS-1:0]   key_store,
  output logic                          key_match
);
  localparam int KEY_W = WORD_W * KEY_WORDS;

  logic [WORD_W-1:0]    word_q [KEY_WORDS];
  logic [WORD_W-1:0]    word_n [KEY_WORDS];
  logic [KEY_WORDS-1:0] vld_q, vld_n;
  logic                 bad_q, bad_n;
  logic [KEY_W-1:0]     flat_n;
  logic                 hit;

  assign hit = addr_in_window(wr_addr, KEY_BASE, KEY_WORDS);

  // next capture state, merged with a write in this cycle (R10)
  always_comb begin
    for (int i = 0; i < KEY_WORDS; i++) word_n[i] = word_q[i];
    vld_n = vld_q;
    bad_n = bad_q;
    if (key_wr_ev) begin
      if (hit) begin
        for (int i = 0; i < KEY_WORDS; i++) begin
          if (slot_of(wr_addr, KEY_BASE) == i) begin
            word_n[i] = wr_data;
            vld_n[i]  = 1'b1;
          end
        end
      end else begin
        bad_n = 1'b1;  // R8: stray write spoils the attempt
      end
    end
  end

  // word 0 is the most significant part of the key (R5)
  for (genvar g = 0; g < KEY_WORDS; g++) begin : g_pack
    assign flat_n[KEY_W-1-g*WORD_W -: WORD_W] = word_n[g];
  end

  assign key_match = (&vld_n) & ~bad_n & (flat_n == key_store);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < KEY_WORDS; i++) word_q[i] <= '0;
      vld_q <= '0;
      bad_q <= 1'b0;
    end else if (compare_ev) begin
      for (int i = 0; i < KEY_WORDS; i++) word_q[i] <= '0;
      vld_q <= '0;
      bad_q <= 1'b0;
    end else if (key_wr_ev) begin
      for (int i = 0; i < KEY_WORDS; i++) word_q[i] <= word_n[i];
      vld_q <= vld_n;
      bad_q <= bad_n;
    end
  end

  a_r9_cleared_after_compare: assert property (@(posedge clk) disable iff (!rst_n)
    compare_ev |=> (vld_q == '0) && !bad_q);
endmodule

// File: rtl/sec_state_reg.sv
module sec_state_reg import sec_bd_pkg::*; #(
  parameter logic [7:0] SEC_RST = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       boot_load,
  input  logic [7:0] boot_byte,
  input  logic       cfg_wr,
  input  logic       cfg_key_acc,
  input  logic       key_match,
  output logic [7:0] sec_q,
  output logic       key_acc,
  output logic       viol,
  output logic       compare_ev
);
  localparam int KEYEN_BIT = 7;

  logic acc_set_ev;

  assign compare_ev = cfg_wr & ~cfg_key_acc & key_acc;
  assign acc_set_ev = cfg_wr & cfg_key_acc & sec_q[KEYEN_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q   <= SEC_RST;
      key_acc <= 1'b0;
      viol    <= 1'b0;
    end else begin
      viol <= compare_ev & ~key_match;
      if (boot_load) sec_q <= boot_byte;
      else if (compare_ev && key_match) sec_q[1:0] <= SEC_OPEN_CODE;
      if (compare_ev) key_acc <= 1'b0;
      else if (acc_set_ev) key_acc <= 1'b1;
    end
  end

  a_r3_keyacc_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(key_acc) |-> $past(sec_q[KEYEN_BIT]));
  a_r6_unlock_code: assert property (@(posedge clk) disable iff (!rst_n)
    (compare_ev && key_match && !boot_load) |=> code_is_open(sec_q[1:0]) && !viol);
  a_r7_viol_single: assert property (@(posedge clk) disable iff (!rst_n)
    viol |=> !viol);
  a_r7_state_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (compare_ev && !key_match && !boot_load) |=> $stable(sec_q) && viol);
endmodule

// File: rtl/sec_access_gate.sv
module sec_access_gate import sec_bd_pkg::*; (
  input  logic [1:0] sec_code,
  input  logic       dbg_rd_req,
  input  logic       ext_rd_req,
  output logic       secured,
  output logic       dbg_rd_gnt,
  output logic       ext_rd_gnt
);
  assign secured    = ~code_is_open(sec_code);
  assign dbg_rd_gnt = dbg_rd_req & ~secured;
  assign ext_rd_gnt = ext_rd_req & ~secured;
endmodule

// File: rtl/sec_backdoor_top.sv
module sec_backdoor_top import sec_bd_pkg::*; #(
  parameter int WORD_W = 16,
  parameter int KEY_WORDS = 4,
  parameter logic [15:0] KEY_BASE = 16'hFF00,
  parameter logic [7:0] SEC_RST = 8'h00
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        boot_load,
  input  logic [7:0]                  boot_byte,
  input  logic [WORD_W*KEY_WORDS-1:0] key_store,
  input  logic                        cfg_wr,
  input  logic                        cfg_key_acc,
  input  logic                        mem_wr,
  input  logic [15:0]                 mem_addr,
  input  logic [WORD_W-1:0]           mem_wdata,
  input  logic                        dbg_rd_req,
  input  logic                        ext_rd_req,
  output logic [7:0]                  sec_byte,
  output logic                        secured,
  output logic                        key_acc,
  output logic                        cmd_wr,
  output logic                        viol,
  output logic                        dbg_rd_gnt,
  output logic                        ext_rd_gnt
);
  logic compare_ev;
  logic key_wr_ev;
  logic key_match;

  assign key_wr_ev = mem_wr & key_acc;
  assign cmd_wr    = mem_wr & ~key_acc;  // R4

  sec_key_capture #(
    .WORD_W(WORD_W), .KEY_WORDS(KEY_WORDS), .KEY_BASE(KEY_BASE)
  ) u_cap (
    .clk(clk), .rst_n(rst_n), .key_wr_ev(key_wr_ev), .compare_ev(compare_ev),
    .wr_addr(mem_addr), .wr_data(mem_wdata), .key_store(key_store),
    .key_match(key_match)
  );

  sec_state_reg #(.SEC_RST(SEC_RST)) u_state (
    .clk(clk), .rst_n(rst_n), .boot_load(boot_load), .boot_byte(boot_byte),
    .cfg_wr(cfg_wr), .cfg_key_acc(cfg_key_acc), .key_match(key_match),
    .sec_q(sec_byte), .key_acc(key_acc), .viol(viol), .compare_ev(compare_ev)
  );

  sec_access_gate u_gate (
    .sec_code(sec_byte[1:0]), .dbg_rd_req(dbg_rd_req), .ext_rd_req(ext_rd_req),
    .secured(secured), .dbg_rd_gnt(dbg_rd_gnt), .ext_rd_gnt(ext_rd_gnt)
  );

  // R2/R6: the lock is lifted only by a boot load or a matching key
  a_r2_unlock_source: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(secured) |-> $past(boot_load) || ($past(compare_ev) && $past(key_match)));
  a_r4_keyacc_swallows: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && key_acc) |-> !cmd_wr);
endmodule

// File: tb/tb_sec_backdoor_top.sv
module tb_sec_backdoor_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        boot_load;
  logic [7:0]  boot_byte;
  logic [63:0] key_store;
  logic        cfg_wr, cfg_key_acc, mem_wr;
  logic [15:0] mem_addr, mem_wdata;
  logic        dbg_rd_req, ext_rd_req;
  logic [7:0]  sec_byte;
  logic        secured, key_acc, cmd_wr, viol, dbg_rd_gnt, ext_rd_gnt;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  localparam logic [63:0] K = 64'h1234_5678_9ABC_DEF0;
  // {expect_open, stray_write, word_mask[3:0], words[63:0]}
  localparam int NV = 6;
  localparam logic [69:0] VEC [NV] = '{
    {1'b1, 1'b0, 4'hF, K},
    {1'b0, 1'b0, 4'hF, 64'h1234_5678_9ABC_DEF1},
    {1'b0, 1'b0, 4'h7, K},
    {1'b0, 1'b1, 4'hF, K},
    {1'b0, 1'b0, 4'hF, 64'h5678_1234_9ABC_DEF0},
    {1'b1, 1'b0, 4'hF, K}
  };

  always #2.5 clk = ~clk;

  sec_backdoor_top dut (
    .clk(clk), .rst_n(rst_n), .boot_load(boot_load), .boot_byte(boot_byte),
    .key_store(key_store), .cfg_wr(cfg_wr), .cfg_key_acc(cfg_key_acc),
    .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .dbg_rd_req(dbg_rd_req), .ext_rd_req(ext_rd_req), .sec_byte(sec_byte),
    .secured(secured), .key_acc(key_acc), .cmd_wr(cmd_wr), .viol(viol),
    .dbg_rd_gnt(dbg_rd_gnt), .ext_rd_gnt(ext_rd_gnt)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic boot(input logic [7:0] b);
    boot_load = 1'b1; boot_byte = b; tick; boot_load = 1'b0;
  endtask

  task automatic set_kacc(input logic v);
    cfg_wr = 1'b1; cfg_key_acc = v; tick; cfg_wr = 1'b0;
  endtask

  task automatic key_write(input logic [15:0] a, input logic [15:0] d);
    mem_wr = 1'b1; mem_addr = a; mem_wdata = d; tick; mem_wr = 1'b0;
  endtask

  function automatic logic [15:0] word_of(input logic [63:0] k, input int i);
    return k[63-16*i -: 16];
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; boot_load = 0; boot_byte = 0; key_store = K;
    cfg_wr = 0; cfg_key_acc = 0; mem_wr = 0; mem_addr = 0; mem_wdata = 0;
    dbg_rd_req = 1'b1; ext_rd_req = 1'b1;
    repeat (3) tick;
    rst_n = 1'b1;
    #1;
    check("R1 sec_byte", 64'(sec_byte), 64'h00);
    check("R1 secured", 64'(secured), 64'd1);
    check("R1 key_acc", 64'(key_acc), 64'd0);
    check("R1 viol", 64'(viol), 64'd0);
    check("R1 grants", 64'({dbg_rd_gnt, ext_rd_gnt}), 64'd0);

    // R2 / R11: every state code; only 2'b10 is open
    for (int c = 0; c < 4; c++) begin
      boot(8'h40 | 8'(c));
      check("R2 load", 64'(sec_byte), 64'(8'h40 | 8'(c)));
      check("R2 secured", 64'(secured), (c == 2) ? 64'd0 : 64'd1);
      check("R11 dbg grant", 64'(dbg_rd_gnt), (c == 2) ? 64'd1 : 64'd0);
      check("R11 ext grant", 64'(ext_rd_gnt), (c == 2) ? 64'd1 : 64'd0);
    end
    ext_rd_req = 1'b0; #1;
    check("R11 ext no req", 64'(ext_rd_gnt), 64'd0);

    // R3 / R4: backdoor disabled
    boot(8'h00);
    set_kacc(1'b1);
    check("R3 key_acc blocked", 64'(key_acc), 64'd0);
    mem_wr = 1'b1; mem_addr = 16'hFF00; mem_wdata = 16'h1234; #1;
    check("R4 cmd passes", 64'(cmd_wr), 64'd1);
    tick; mem_wr = 1'b0;
    set_kacc(1'b0);
    check("R7 no compare without key access", 64'(viol), 64'd0);

    // R3 / R4: backdoor enabled
    boot(8'h80);
    set_kacc(1'b1);
    check("R3 key_acc set", 64'(key_acc), 64'd1);
    mem_wr = 1'b1; mem_addr = 16'hFF00; mem_wdata = 16'h1234; #1;
    check("R4 cmd swallowed", 64'(cmd_wr), 64'd0);
    tick; mem_wr = 1'b0;
    set_kacc(1'b0);
    check("R8 one word only", 64'(viol), 64'd1);
    check("R3 key_acc cleared", 64'(key_acc), 64'd0);

    // table of unlock attempts (R5 R6 R7 R8)
    for (int v = 0; v < NV; v++) begin
      logic        exp_open;
      logic        stray;
      logic [3:0]  mask;
      logic [63:0] words;
      {exp_open, stray, mask, words} = VEC[v];
      boot(8'h84);
      check("R2 relocked", 64'(secured), 64'd1);
      set_kacc(1'b1);
      for (int i = 0; i < 4; i++)
        if (mask[i]) key_write(16'hFF00 + 16'(2 * i), word_of(words, i));
      if (stray) key_write(16'hFF08, 16'h0000);
      set_kacc(1'b0);
      check("R6 R7 state code", 64'(sec_byte[1:0]), exp_open ? 64'd2 : 64'd0);
      check("R6 upper bits kept", 64'(sec_byte[7:2]), 64'h21);
      check("R7 viol pulse", 64'(viol), exp_open ? 64'd0 : 64'd1);
      tick;
      check("R7 viol single cycle", 64'(viol), 64'd0);
    end

    // R8: odd address inside the window
    boot(8'h80);
    set_kacc(1'b1);
    for (int i = 0; i < 4; i++) key_write(16'hFF00 + 16'(2 * i), word_of(K, i));
    key_write(16'hFF03, 16'h5678);
    set_kacc(1'b0);
    check("R8 odd address", 64'(secured), 64'd1);

    // R9: words discarded after a failed attempt
    set_kacc(1'b1);
    for (int i = 0; i < 3; i++) key_write(16'hFF00 + 16'(2 * i), word_of(K, i));
    key_write(16'hFF06, 16'hBEEF);
    set_kacc(1'b0);
    check("R9 first attempt fails", 64'(viol), 64'd1);
    set_kacc(1'b1);
    key_write(16'hFF06, word_of(K, 3));
    set_kacc(1'b0);
    check("R9 stale words not reused", 64'(secured), 64'd1);
    check("R9 viol", 64'(viol), 64'd1);

    // R10: last word together with clearing key access
    set_kacc(1'b1);
    for (int i = 0; i < 3; i++) key_write(16'hFF00 + 16'(2 * i), word_of(K, i));
    mem_wr = 1'b1; mem_addr = 16'hFF06; mem_wdata = 16'h0BAD;
    cfg_wr = 1'b1; cfg_key_acc = 1'b0;
    tick; mem_wr = 1'b0; cfg_wr = 1'b0;
    check("R10 wrong same-cycle word", 64'(viol), 64'd1);
    set_kacc(1'b1);
    for (int i = 0; i < 3; i++) key_write(16'hFF00 + 16'(2 * i), word_of(K, i));
    mem_wr = 1'b1; mem_addr = 16'hFF06; mem_wdata = word_of(K, 3);
    cfg_wr = 1'b1; cfg_key_acc = 1'b0;
    tick; mem_wr = 1'b0; cfg_wr = 1'b0;
    check("R10 same-cycle word opens", 64'(secured), 64'd0);
    check("R10 no viol", 64'(viol), 64'd0);
    check("R11 dbg grant after unlock", 64'(dbg_rd_gnt), 64'd1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule